// File: doc/BRIEF.md
# Byte-Serial Command Register Interface

This block is the slave-side command decoder behind a byte-oriented serial bus. A bus front end, which is not part of this block, reports four events as single-cycle strobes: start of a write transaction, start of a read transaction, a received byte, and a request for a byte to send. In a write transaction the first byte picks a command and the bytes after it are that command's parameters. In a read transaction each requested byte is produced from the command latched most recently.

The decoder holds a set of device settings: configuration, active time, debounce time, keypad geometry, clock setup, and the GPIO pull, direction and state words. It also holds a pattern store for the waveform engine and a sticky error register. Every parameter is checked as it arrives. Once a command has taken its final parameter, the latched command becomes a spent marker, so any surplus byte is reported as a bad parameter. The waveform engine connects through a start strobe, a stop strobe and a read port on the pattern store. The interrupt logic connects through an error flag.

Top module: `byte_cmd_regs`

## Requirements
- R1: A write-start or read-start strobe clears both byte counters, and any data strobe in that same cycle is ignored. The first byte of a write latches the command, and later bytes are parameters numbered from 0.
- R2: When a command takes its final parameter, the latched command becomes 0xFF. Any parameter written while the command is 0xFF sets error bit 0 (bad parameter) and changes no setting.
- R3: An unrecognised command code sets error bit 1 (unknown command), whether it is read or written with a parameter. A read of it returns 0x00.
- R4: Command 0x83 with parameter 0xAA restores configuration 0x80, active time 125, debounce 3, keypad size 0x33 and clock 0x08. Any other parameter sets error bit 0 and changes nothing.
- R5: Commands 0x84 (pull), 0x85 (direction) and 0x86 (state) take the low byte first, then the high byte. Reads with 0x87 (direction) and 0x88 (state) return the low byte, then the high byte, then 0x00.
- R6: Command 0x8F stores the debounce value. A value of zero is still stored, but it also sets error bit 0.
- R7: Command 0x90 stores the keypad size and sets error bit 0 unless bits 7:4 lie in 3..8 and bits 3:0 lie in 3..12. Command 0x91 reads the size back.
- R8: Command 0x93 stores the clock byte and sets error bit 0 when bits 1:0 are 01 or 10. Command 0x94 reads {bits 7:2, 2'b10}. Command 0x92 reads {4'h0, configuration bits 3:0}.
- R9: Command 0x80 returns the identifier 0x0400 with the low byte first, one byte per read, then 0x00.
- R10: Command 0x95 takes a slot byte, a high byte and a low byte. The slot byte is valid only when bits 1:0 are nonzero and bits 7:2 are at most 59. A valid slot byte becomes the entry address and clears that entry. An invalid one sets error bit 0 and ends the command. An entry read at address A appears on the read port one cycle later.
- R11: Commands 0x96 (start) and 0x97 (stop) take one byte whose bits 1:0 pick channel 1..3. Channel 0 sets error bit 0 and produces no strobe. For 0x96 the byte must also pass the R10 slot rule, and bits 7:2 are the start address. A valid byte pulses the matching strobe for one cycle, with the channel and the address on the outputs.
- R12: The error register reads back through command 0x8C. Only the reset input clears it, so command 0x83 leaves it set. The error flag output is high whenever any bit is set.
- R13: Command 0x81 stores the configuration byte and command 0x8B stores the active time. Each takes one parameter, and the values appear on their outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores every register |
| wr_start | input | 1 | Write transaction begins |
| rd_start | input | 1 | Read transaction begins |
| wr_vld | input | 1 | Received byte strobe |
| wr_data | input | 8 | Received byte |
| rd_req | input | 1 | Request for the next byte to send |
| rd_data | output | 8 | Byte to send, valid the cycle after rd_req |
| cfg_o | output | 8 | Configuration setting |
| act_time_o | output | 8 | Active time setting |
| debounce_o | output | 8 | Debounce setting |
| kpd_size_o | output | 8 | Keypad size, rows in bits 7:4 and columns in bits 3:0 |
| clk_cfg_o | output | 8 | Clock setting |
| gpio_pull_o | output | 16 | GPIO pull selection |
| gpio_dir_o | output | 16 | GPIO direction |
| gpio_state_o | output | 16 | GPIO state |
| err_flag_o | output | 1 | Any error bit is set |
| pwm_start_o | output | 1 | One-cycle start request to the waveform engine |
| pwm_stop_o | output | 1 | One-cycle stop request to the waveform engine |
| pwm_chan_o | output | 2 | Channel (1..3) for a start or stop request |
| pwm_addr_o | output | 6 | Start address for a start request |
| pat_raddr | input | PAT_AW | Pattern store read address |
| pat_rdata | output | PAT_DW | Pattern store read data, one cycle after the address |

## Verification
The hardest state to reach is the spent-command state after a partly failed pattern write. A slot byte that fails its check ends the command at once, so the bytes that would have been high and low data must be caught as surplus. They must also leave a neighbouring entry untouched. The bench first writes an entry, then overwrites it with a two-byte sequence so that the clear on the slot byte is seen. It then sends a rejected slot byte followed by two more bytes, and reads the earlier entry and the error register back through the ports. Errors are sticky, so each error scenario starts from a fresh reset. This lets each one observe only the bit it is meant to set.

// File: rtl/byte_cmd_regs_pkg.sv
package byte_cmd_regs_pkg;

   // command codes
   localparam logic [7:0] CMD_ID       = 8'h80;
   localparam logic [7:0] CMD_CFG_WR   = 8'h81;
   localparam logic [7:0] CMD_SRST     = 8'h83;
   localparam logic [7:0] CMD_PULL_WR  = 8'h84;
   localparam logic [7:0] CMD_DIR_WR   = 8'h85;
   localparam logic [7:0] CMD_STATE_WR = 8'h86;
   localparam logic [7:0] CMD_DIR_RD   = 8'h87;
   localparam logic [7:0] CMD_STATE_RD = 8'h88;
   localparam logic [7:0] CMD_ACT_WR   = 8'h8B;
   localparam logic [7:0] CMD_ERR_RD   = 8'h8C;
   localparam logic [7:0] CMD_DEB_WR   = 8'h8F;
   localparam logic [7:0] CMD_KPD_WR   = 8'h90;
   localparam logic [7:0] CMD_KPD_RD   = 8'h91;
   localparam logic [7:0] CMD_CFG_RD   = 8'h92;
   localparam logic [7:0] CMD_CLK_WR   = 8'h93;
   localparam logic [7:0] CMD_CLK_RD   = 8'h94;
   localparam logic [7:0] CMD_PAT_WR   = 8'h95;
   localparam logic [7:0] CMD_PWM_GO   = 8'h96;
   localparam logic [7:0] CMD_PWM_HALT = 8'h97;
   localparam logic [7:0] CMD_SPENT    = 8'hFF;

   localparam logic [7:0] SRST_KEY     = 8'hAA;

   // settings after reset
   localparam logic [7:0] DEF_CFG = 8'h80;
   localparam logic [7:0] DEF_ACT = 8'd125;
   localparam logic [7:0] DEF_DEB = 8'd3;
   localparam logic [7:0] DEF_KPD = 8'h33;
   localparam logic [7:0] DEF_CLK = 8'h08;

   localparam int ERR_BAD = 0;
   localparam int ERR_UNK = 1;

   typedef struct packed {
      logic last;   // final parameter of the command
      logic bad;    // parameter rejected
      logic unk;    // command not recognised
   } pchk_t;

endpackage

// File: rtl/byte_cmd_param_chk.sv
module byte_cmd_param_chk
   import byte_cmd_regs_pkg::*;
#(
   parameter int MIN_DIM  = 3,
   parameter int MAX_ROWS = 8,
   parameter int MAX_COLS = 12,
   parameter int SLOT_MAX = 59
) (
   input  logic [7:0] cmd,
   input  logic [1:0] pidx,
   input  logic [7:0] val,
   output pchk_t      res
);

   logic slot_bad;
   logic size_bad;

   assign slot_bad = (val[1:0] == 2'b00) || (int'(val[7:2]) > SLOT_MAX);
   assign size_bad = (int'(val[7:4]) < MIN_DIM) || (int'(val[7:4]) > MAX_ROWS) ||
                     (int'(val[3:0]) < MIN_DIM) || (int'(val[3:0]) > MAX_COLS);

   always_comb begin
      res = '0;
      case (cmd)
         CMD_CFG_WR, CMD_ACT_WR: res.last = 1'b1;
         CMD_SRST: begin
            res.last = 1'b1;
            res.bad  = (val != SRST_KEY);
         end
         CMD_PULL_WR, CMD_DIR_WR, CMD_STATE_WR: res.last = (pidx != 2'd0);
         CMD_DEB_WR: begin
            res.last = 1'b1;
            res.bad  = (val == 8'h00);
         end
         CMD_KPD_WR: begin
            res.last = 1'b1;
            res.bad  = size_bad;
         end
         CMD_CLK_WR: begin
            res.last = 1'b1;
            res.bad  = ^val[1:0];
         end
         CMD_PAT_WR: begin
            if (pidx == 2'd0) begin
               res.bad  = slot_bad;
               res.last = slot_bad;
            end else begin
               res.last = (pidx >= 2'd2);
            end
         end
         CMD_PWM_GO: begin
            res.last = 1'b1;
            res.bad  = slot_bad;
         end
         CMD_PWM_HALT: begin
            res.last = 1'b1;
            res.bad  = (val[1:0] == 2'b00);
         end
         CMD_SPENT: res.bad = 1'b1;
         default:   res.unk = 1'b1;
      endcase
   end

endmodule

// File: rtl/byte_cmd_rd_mux.sv
module byte_cmd_rd_mux
   import byte_cmd_regs_pkg::*;
#(
   parameter logic [15:0] ID_VAL = 16'h0400
) (
   input  logic [7:0]  cmd,
   input  logic [1:0]  ridx,
   input  logic [15:0] dir,
   input  logic [15:0] state,
   input  logic [7:0]  err,
   input  logic [7:0]  kpd,
   input  logic [3:0]  cfg_lo,
   input  logic [5:0]  clk_hi,
   output logic [7:0]  data,
   output logic        unk
);

   function automatic logic [7:0] pick16(input logic [15:0] w, input logic [1:0] i);
      case (i)
         2'd0:    pick16 = w[7:0];
         2'd1:    pick16 = w[15:8];
         default: pick16 = 8'h00;
      endcase
   endfunction

   always_comb begin
      unk  = 1'b0;
      data = 8'h00;
      case (cmd)
         CMD_ID:       data = pick16(ID_VAL, ridx);
         CMD_DIR_RD:   data = pick16(dir, ridx);
         CMD_STATE_RD: data = pick16(state, ridx);
         CMD_ERR_RD:   data = err;
         CMD_KPD_RD:   data = kpd;
         CMD_CFG_RD:   data = {4'h0, cfg_lo};
         CMD_CLK_RD:   data = {clk_hi, 2'b10};
         default:      unk  = 1'b1;
      endcase
   end

endmodule

// File: rtl/byte_cmd_pat_store.sv
module byte_cmd_pat_store #(
   parameter int AW     = 8,
   parameter int DW     = 16,
   parameter bit REG_RD = 1'b1
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      if (REG_RD) begin : g_reg_rd
         always_ff @(posedge clk) rdata <= mem[raddr];
      end else begin : g_comb_rd
         assign rdata = mem[raddr];
      end
   endgenerate

endmodule

// File: rtl/byte_cmd_regs.sv
module byte_cmd_regs
   import byte_cmd_regs_pkg::*;
#(
   parameter int          PAT_AW     = 8,
   parameter int          PAT_DW     = 16,
   parameter bit          PAT_REG_RD = 1'b1,
   parameter logic [15:0] ID_VAL     = 16'h0400,
   parameter int          MIN_DIM    = 3,
   parameter int          MAX_ROWS   = 8,
   parameter int          MAX_COLS   = 12,
   parameter int          SLOT_MAX   = 59
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic              rd_start,
   input  logic              wr_vld,
   input  logic [7:0]        wr_data,
   input  logic              rd_req,
   output logic [7:0]        rd_data,
   output logic [7:0]        cfg_o,
   output logic [7:0]        act_time_o,
   output logic [7:0]        debounce_o,
   output logic [7:0]        kpd_size_o,
   output logic [7:0]        clk_cfg_o,
   output logic [15:0]       gpio_pull_o,
   output logic [15:0]       gpio_dir_o,
   output logic [15:0]       gpio_state_o,
   output logic              err_flag_o,
   output logic              pwm_start_o,
   output logic              pwm_stop_o,
   output logic [1:0]        pwm_chan_o,
   output logic [5:0]        pwm_addr_o,
   input  logic [PAT_AW-1:0] pat_raddr,
   output logic [PAT_DW-1:0] pat_rdata
);

   localparam logic [1:0] CNT_SAT = 2'd3;

   generate
      if (PAT_AW < 8) begin : g_bad_aw
         $error("PAT_AW must hold a full slot byte");
      end
      if (PAT_DW != 16) begin : g_bad_dw
         $error("PAT_DW must be two bytes");
      end
      if (SLOT_MAX > 63) begin : g_bad_slot
         $error("SLOT_MAX must fit in six bits");
      end
      if (MAX_COLS > 15 || MAX_ROWS > 15) begin : g_bad_dim
         $error("keypad limits must fit in a nibble");
      end
   endgenerate

   logic [1:0]        wcnt_q, rcnt_q, pidx;
   logic [7:0]        cmd_q, err_q, pat_hi_q;
   logic [PAT_AW-1:0] pat_addr_q;
   logic              any_start, param_act, rd_act;
   pchk_t             chk;
   logic [7:0]        mux_data;
   logic              mux_unk;
   logic              pat_we;
   logic [PAT_AW-1:0] pat_waddr;
   logic [PAT_DW-1:0] pat_wdata;

   assign any_start = wr_start | rd_start;
   assign pidx      = wcnt_q - 2'd1;
   assign param_act = wr_vld && !any_start && (wcnt_q != 2'd0);
   assign rd_act    = rd_req && !any_start;

   byte_cmd_param_chk #(
      .MIN_DIM(MIN_DIM), .MAX_ROWS(MAX_ROWS),
      .MAX_COLS(MAX_COLS), .SLOT_MAX(SLOT_MAX)
   ) u_pchk (
      .cmd(cmd_q), .pidx(pidx), .val(wr_data), .res(chk)
   );

   byte_cmd_rd_mux #(.ID_VAL(ID_VAL)) u_rmux (
      .cmd(cmd_q), .ridx(rcnt_q), .dir(gpio_dir_o), .state(gpio_state_o),
      .err(err_q), .kpd(kpd_size_o), .cfg_lo(cfg_o[3:0]), .clk_hi(clk_cfg_o[7:2]),
      .data(mux_data), .unk(mux_unk)
   );

   // pattern entry: slot byte clears, then high byte, then low byte
   assign pat_we    = param_act && (cmd_q == CMD_PAT_WR) && !chk.bad;
   assign pat_waddr = (pidx == 2'd0) ? PAT_AW'(wr_data) : pat_addr_q;
   assign pat_wdata = (pidx == 2'd0) ? '0 :
                      (pidx == 2'd1) ? {wr_data, 8'h00} : {pat_hi_q, wr_data};

   byte_cmd_pat_store #(.AW(PAT_AW), .DW(PAT_DW), .REG_RD(PAT_REG_RD)) u_pat (
      .clk(clk), .we(pat_we), .waddr(pat_waddr), .wdata(pat_wdata),
      .raddr(pat_raddr), .rdata(pat_rdata)
   );

   assign err_flag_o = |err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcnt_q       <= '0;
         rcnt_q       <= '0;
         cmd_q        <= CMD_SPENT;
         err_q        <= '0;
         rd_data      <= '0;
         cfg_o        <= DEF_CFG;
         act_time_o   <= DEF_ACT;
         debounce_o   <= DEF_DEB;
         kpd_size_o   <= DEF_KPD;
         clk_cfg_o    <= DEF_CLK;
         gpio_pull_o  <= '0;
         gpio_dir_o   <= '0;
         gpio_state_o <= '0;
         pat_addr_q   <= '0;
         pat_hi_q     <= '0;
         pwm_start_o  <= 1'b0;
         pwm_stop_o   <= 1'b0;
         pwm_chan_o   <= '0;
         pwm_addr_o   <= '0;
      end else begin
         pwm_start_o <= 1'b0;
         pwm_stop_o  <= 1'b0;
         if (any_start) begin
            wcnt_q <= '0;
            rcnt_q <= '0;
         end
         if (wr_vld && !any_start) begin
            if (wcnt_q != CNT_SAT) wcnt_q <= wcnt_q + 2'd1;
            if (wcnt_q == 2'd0) cmd_q <= wr_data;
         end
         if (param_act) begin
            if (chk.unk)  err_q[ERR_UNK] <= 1'b1;
            if (chk.bad)  err_q[ERR_BAD] <= 1'b1;
            if (chk.last) cmd_q <= CMD_SPENT;
            case (cmd_q)
               CMD_CFG_WR: cfg_o      <= wr_data;
               CMD_ACT_WR: act_time_o <= wr_data;
               CMD_DEB_WR: debounce_o <= wr_data;
               CMD_KPD_WR: kpd_size_o <= wr_data;
               CMD_CLK_WR: clk_cfg_o  <= wr_data;
               CMD_SRST: begin
                  if (!chk.bad) begin
                     cfg_o      <= DEF_CFG;
                     act_time_o <= DEF_ACT;
                     debounce_o <= DEF_DEB;
                     kpd_size_o <= DEF_KPD;
                     clk_cfg_o  <= DEF_CLK;
                  end
               end
               CMD_PULL_WR: begin
                  if (pidx == 2'd0) gpio_pull_o <= {8'h00, wr_data};
                  else              gpio_pull_o[15:8] <= wr_data;
               end
               CMD_DIR_WR: begin
                  if (pidx == 2'd0) gpio_dir_o <= {8'h00, wr_data};
                  else              gpio_dir_o[15:8] <= wr_data;
               end
               CMD_STATE_WR: begin
                  if (pidx == 2'd0) gpio_state_o <= {8'h00, wr_data};
                  else              gpio_state_o[15:8] <= wr_data;
               end
               CMD_PAT_WR: begin
                  if (pidx == 2'd0 && !chk.bad) pat_addr_q <= PAT_AW'(wr_data);
                  if (pidx == 2'd1)             pat_hi_q   <= wr_data;
               end
               CMD_PWM_GO: begin
                  if (!chk.bad) begin
                     pwm_start_o <= 1'b1;
                     pwm_chan_o  <= wr_data[1:0];
                     pwm_addr_o  <= wr_data[7:2];
                  end
               end
               CMD_PWM_HALT: begin
                  if (!chk.bad) begin
                     pwm_stop_o <= 1'b1;
                     pwm_chan_o <= wr_data[1:0];
                  end
               end
               default: ;
            endcase
         end
         if (rd_act) begin
            rd_data <= mux_data;
            if (mux_unk) err_q[ERR_UNK] <= 1'b1;
            if (rcnt_q != CNT_SAT) rcnt_q <= rcnt_q + 2'd1;
         end
      end
   end

endmodule

// File: rtl/byte_cmd_regs_chk.sv
module byte_cmd_regs_chk #(
   parameter logic [15:0] ID_VAL   = 16'h0400,
   parameter int          SLOT_MAX = 59
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_start,
   input logic       rd_start,
   input logic       wr_vld,
   input logic [7:0] wr_data,
   input logic       rd_req,
   input logic [7:0] rd_data,
   input logic [1:0] wcnt,
   input logic [1:0] rcnt,
   input logic [7:0] cmd,
   input logic [7:0] err,
   input logic       pwm_start,
   input logic       pwm_stop,
   input logic [1:0] pwm_chan,
   input logic [5:0] pwm_addr
);

   logic quiet;
   assign quiet = !wr_start && !rd_start;

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_start || rd_start) |=> (wcnt == 2'd0 && rcnt == 2'd0)); // R1

   AST_CMD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld && quiet && wcnt == 2'd0) |=> (cmd == $past(wr_data))); // R1

   AST_SPENT_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld && quiet && wcnt != 2'd0 && cmd == 8'hFF) |=> err[0]); // R2

   AST_ID_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && quiet && cmd == 8'h80 && rcnt == 2'd0) |=> (rd_data == ID_VAL[7:0])); // R9

   AST_ID_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && quiet && cmd == 8'h80 && rcnt == 2'd1) |=> (rd_data == ID_VAL[15:8])); // R9

   AST_CLK_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && quiet && cmd == 8'h94) |=> (rd_data[1:0] == 2'b10)); // R8

   AST_CFG_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && quiet && cmd == 8'h92) |=> (rd_data[7:4] == 4'h0)); // R8

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err != 8'h00) |=> ((err & $past(err)) == $past(err))); // R12

   AST_GO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_start |-> (pwm_chan != 2'b00 && int'(pwm_addr) <= SLOT_MAX)); // R11

   AST_HALT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_stop |-> (pwm_chan != 2'b00 && !pwm_start)); // R11

endmodule

bind byte_cmd_regs byte_cmd_regs_chk #(.ID_VAL(ID_VAL), .SLOT_MAX(SLOT_MAX)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .rd_start(rd_start),
   .wr_vld(wr_vld), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
   .wcnt(wcnt_q), .rcnt(rcnt_q), .cmd(cmd_q), .err(err_q),
   .pwm_start(pwm_start_o), .pwm_stop(pwm_stop_o),
   .pwm_chan(pwm_chan_o), .pwm_addr(pwm_addr_o)
);

// File: tb/byte_cmd_regs_bench.sv
`timescale 1ns/1ps
module byte_cmd_regs_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_start = 1'b0, rd_start = 1'b0, wr_vld = 1'b0, rd_req = 1'b0;
   logic [7:0]  wr_data = 8'h00;
   logic [7:0]  rd_data, cfg_o, act_time_o, debounce_o, kpd_size_o, clk_cfg_o;
   logic [15:0] gpio_pull_o, gpio_dir_o, gpio_state_o;
   logic        err_flag_o, pwm_start_o, pwm_stop_o;
   logic [1:0]  pwm_chan_o;
   logic [5:0]  pwm_addr_o;
   logic [7:0]  pat_raddr = 8'h00;
   logic [15:0] pat_rdata;

   int n_chk = 0, n_fail = 0;
   logic       cap_start, cap_stop;
   logic [1:0] cap_chan;
   logic [5:0] cap_addr;

   always #2.5 clk = ~clk;

   byte_cmd_regs u_byte_cmd_regs (
      .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .rd_start(rd_start),
      .wr_vld(wr_vld), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
      .cfg_o(cfg_o), .act_time_o(act_time_o), .debounce_o(debounce_o),
      .kpd_size_o(kpd_size_o), .clk_cfg_o(clk_cfg_o), .gpio_pull_o(gpio_pull_o),
      .gpio_dir_o(gpio_dir_o), .gpio_state_o(gpio_state_o), .err_flag_o(err_flag_o),
      .pwm_start_o(pwm_start_o), .pwm_stop_o(pwm_stop_o), .pwm_chan_o(pwm_chan_o),
      .pwm_addr_o(pwm_addr_o), .pat_raddr(pat_raddr), .pat_rdata(pat_rdata)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic hw_reset();
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic ws();
      @(negedge clk) wr_start = 1'b1;
      @(negedge clk) wr_start = 1'b0;
   endtask

   task automatic rs();
      @(negedge clk) rd_start = 1'b1;
      @(negedge clk) rd_start = 1'b0;
   endtask

   task automatic wb(input logic [7:0] v);
      @(negedge clk);
      wr_vld = 1'b1; wr_data = v;
      @(posedge clk); #1;
      cap_start = pwm_start_o; cap_stop = pwm_stop_o;
      cap_chan = pwm_chan_o;   cap_addr = pwm_addr_o;
      @(negedge clk) wr_vld = 1'b0;
   endtask

   task automatic rb(output logic [7:0] v);
      @(negedge clk) rd_req = 1'b1;
      @(negedge clk) rd_req = 1'b0;
      v = rd_data;
   endtask

   task automatic w1(input logic [7:0] c, input logic [7:0] p);
      ws(); wb(c); wb(p);
   endtask

   task automatic w2(input logic [7:0] c, input logic [7:0] lo, input logic [7:0] hi);
      ws(); wb(c); wb(lo); wb(hi);
   endtask

   task automatic rd1(input logic [7:0] c, output logic [7:0] v);
      ws(); wb(c); rs(); rb(v);
   endtask

   task automatic err_is(input string tag, input logic [7:0] exp);
      logic [7:0] v;
      rd1(8'h8C, v);
      check(tag, {8'h00, v}, {8'h00, exp});
   endtask

   task automatic pat_is(input string tag, input logic [7:0] a, input logic [15:0] exp);
      @(negedge clk) pat_raddr = a;
      @(negedge clk);
      check(tag, pat_rdata, exp);
   endtask

   task automatic t_reset_state();
      hw_reset();
      check("R4 cfg default", {8'h00, cfg_o}, 16'h0080);
      check("R4 active default", {8'h00, act_time_o}, 16'd125);
      check("R4 debounce default", {8'h00, debounce_o}, 16'd3);
      check("R4 keypad default", {8'h00, kpd_size_o}, 16'h0033);
      check("R4 clock default", {8'h00, clk_cfg_o}, 16'h0008);
      check("R12 flag low", {15'h0, err_flag_o}, 16'h0000);
      err_is("R12 err zero", 8'h00);
   endtask

   task automatic t_ident();
      logic [7:0] v;
      hw_reset();
      ws(); wb(8'h80); rs();
      rb(v); check("R9 id byte0", {8'h00, v}, 16'h0000);
      rb(v); check("R9 id byte1", {8'h00, v}, 16'h0004);
      rb(v); check("R9 id byte2", {8'h00, v}, 16'h0000);
      rs(); rb(v); check("R1 read restart", {8'h00, v}, 16'h0000);
      err_is("R9 no error", 8'h00);
   endtask

   task automatic t_gpio();
      logic [7:0] v;
      hw_reset();
      ws(); wb(8'h84); wb(8'h11);
      w2(8'h84, 8'h22, 8'h33);
      check("R1 restart mid command", gpio_pull_o, 16'h3322);
      w2(8'h85, 8'h34, 8'h12);
      w2(8'h86, 8'hCD, 8'hAB);
      check("R5 dir out", gpio_dir_o, 16'h1234);
      check("R5 state out", gpio_state_o, 16'hABCD);
      ws(); wb(8'h87); rs();
      rb(v); check("R5 dir lo", {8'h00, v}, 16'h0034);
      rb(v); check("R5 dir hi", {8'h00, v}, 16'h0012);
      rb(v); check("R5 dir third", {8'h00, v}, 16'h0000);
      ws(); wb(8'h88); rs();
      rb(v); check("R5 state lo", {8'h00, v}, 16'h00CD);
      rb(v); check("R5 state hi", {8'h00, v}, 16'h00AB);
      err_is("R5 no error", 8'h00);
   endtask

   task automatic t_single();
      logic [7:0] v;
      hw_reset();
      w1(8'h81, 8'h5A);
      check("R13 cfg out", {8'h00, cfg_o}, 16'h005A);
      rd1(8'h92, v); check("R8 cfg nibble", {8'h00, v}, 16'h000A);
      w1(8'h8B, 8'h40);
      check("R13 active out", {8'h00, act_time_o}, 16'h0040);
      w1(8'h90, 8'h8C);
      rd1(8'h91, v); check("R7 size read", {8'h00, v}, 16'h008C);
      w1(8'h93, 8'h0B);
      rd1(8'h94, v); check("R8 clock read", {8'h00, v}, 16'h000A);
      err_is("R7 R8 legal no error", 8'h00);
   endtask

   task automatic t_spent();
      hw_reset();
      ws(); wb(8'h8B); wb(8'h11); wb(8'h22);
      check("R2 extra byte ignored", {8'h00, act_time_o}, 16'h0011);
      check("R2 flag", {15'h0, err_flag_o}, 16'h0001);
      err_is("R2 bad bit", 8'h01);
   endtask

   task automatic t_unknown();
      logic [7:0] v;
      hw_reset();
      w1(8'h8D, 8'h05);
      err_is("R3 write unknown", 8'h02);
      hw_reset();
      rd1(8'h8D, v);
      check("R3 read zero", {8'h00, v}, 16'h0000);
      err_is("R3 read unknown", 8'h02);
   endtask

   task automatic t_softreset();
      hw_reset();
      w1(8'h81, 8'h55);
      w1(8'h8F, 8'h07);
      w1(8'h83, 8'h12);
      check("R4 bad key keeps cfg", {8'h00, cfg_o}, 16'h0055);
      err_is("R4 bad key error", 8'h01);
      w1(8'h83, 8'hAA);
      check("R4 key restores cfg", {8'h00, cfg_o}, 16'h0080);
      check("R4 key restores debounce", {8'h00, debounce_o}, 16'd3);
      err_is("R12 survives soft reset", 8'h01);
   endtask

   task automatic t_param_errs();
      hw_reset();
      w1(8'h8F, 8'h00);
      check("R6 zero stored", {8'h00, debounce_o}, 16'h0000);
      err_is("R6 zero error", 8'h01);
      hw_reset();
      w1(8'h90, 8'h93);
      check("R7 rows stored", {8'h00, kpd_size_o}, 16'h0093);
      err_is("R7 rows too many", 8'h01);
      hw_reset();
      w1(8'h90, 8'h3D);
      err_is("R7 cols too many", 8'h01);
      hw_reset();
      w1(8'h93, 8'h09);
      check("R8 clock stored", {8'h00, clk_cfg_o}, 16'h0009);
      err_is("R8 clock bad bits", 8'h01);
   endtask

   task automatic t_pattern();
      hw_reset();
      ws(); wb(8'h95); wb(8'h09); wb(8'hBE); wb(8'hEF);
      pat_is("R10 full entry", 8'h09, 16'hBEEF);
      ws(); wb(8'h95); wb(8'h09); wb(8'h12);
      pat_is("R10 slot clears", 8'h09, 16'h1200);
      err_is("R10 legal no error", 8'h00);
      ws(); wb(8'h95); wb(8'h08); wb(8'h77); wb(8'h66);
      pat_is("R10 rejected slot untouched", 8'h09, 16'h1200);
      err_is("R10 channel zero error", 8'h01);
      hw_reset();
      w1(8'h95, 8'hF1);
      err_is("R10 slot above 59", 8'h01);
   endtask

   task automatic t_pwm();
      hw_reset();
      w1(8'h96, 8'hED);
      check("R11 start pulse", {15'h0, cap_start}, 16'h0001);
      check("R11 start chan", {14'h0, cap_chan}, 16'h0001);
      check("R11 start addr", {10'h0, cap_addr}, 16'd59);
      w1(8'h97, 8'h03);
      check("R11 stop pulse", {15'h0, cap_stop}, 16'h0001);
      check("R11 stop chan", {14'h0, cap_chan}, 16'h0003);
      err_is("R11 legal no error", 8'h00);
      w1(8'h96, 8'hF2);
      check("R11 addr 60 no pulse", {15'h0, cap_start}, 16'h0000);
      err_is("R11 addr 60 error", 8'h01);
      hw_reset();
      w1(8'h97, 8'hFC);
      check("R11 chan0 no stop", {15'h0, cap_stop}, 16'h0000);
      err_is("R11 chan0 error", 8'h01);
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset_state();
      t_ident();
      t_gpio();
      t_single();
      t_spent();
      t_unknown();
      t_softreset();
      t_param_errs();
      t_pattern();
      t_pwm();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule